// File: doc/BRIEF.md
# Masked Sticky Interrupt and Fault Classifier

This block gathers fault and event indications into two 8-bit sticky status registers. Group A holds the thermal and housekeeping events and group B holds the converter and rail faults. Each group has its own enable mask. The block drives an active-low interrupt pin and an active-low power-good pin, which the surrounding logic treats as open-drain. It also sorts faults into shutdown requests for the rail sequencer. A host reads a status register to see what happened, and that read clears the register. A fault that is still present is picked up again on the next periodic resample. The bus protocol and the analog detectors are outside this block.

Shutdown handling is a five-state machine:

- `SD_RUN`: no shutdown-class fault is latched.
- `SD_ORDER`: issues a one-cycle ordered-shutdown pulse.
- `SD_IMMED`: issues a one-cycle immediate-shutdown pulse.
- `SD_HOLD_ORD`: waits after an ordered shutdown.
- `SD_HOLD_IMM`: waits after an immediate shutdown.

The transitions are as follows:

- From `SD_RUN`: go to `SD_IMMED` if the common-voltage fault bit is set. Otherwise go to `SD_ORDER` if any ordered-class bit is set.
- From `SD_ORDER`: go to `SD_IMMED` if the common-voltage bit is set. Otherwise go to `SD_HOLD_ORD`.
- From `SD_IMMED`: always go to `SD_HOLD_IMM`.
- From `SD_HOLD_ORD`: escalate to `SD_IMMED` if the common-voltage bit sets. Return to `SD_RUN` once no ordered-class bit remains set.
- From `SD_HOLD_IMM`: return to `SD_RUN` once no shutdown-class bit of either kind remains set.

Top module: `irq_fault_unit`

## Requirements
- R1: After reset, both status registers are 0, the group A enable is 0xDF (bit 5, the temperature-change enable, is 0) and the group B enable is 0xFF. In this state irq_n=1, pgood_n=1, both shutdown pulses are 0 and reenable_blocked=0.
- R2: Event-type sources (group A bits 3..7, group B bit 7) set their status bit on the next clock edge while the source is 1. A read strobe at rd_addr 0 (group A), 1 (group B), 2 (enable A) or 3 (enable B) returns that register's value on rd_data one cycle later.
- R3: Level-type sources (group A bits 0..2, group B bits 0..6) are captured only on the resample tick, which occurs once every RESAMPLE_CYC cycles. A level that is high only between ticks sets nothing.
- R4: irq_n is 0 exactly when some status bit is set and its enable bit is 1. Enable bits never block a status bit from setting. Writes to addresses 2 and 3 load the enables; writes to addresses 0 and 1 are ignored.
- R5: A read of a status register clears its bits at the same edge. A bit whose set condition is true at that edge stays set (set wins over clear).
- R6: A level fault that persists after a clearing read sets its bit again within RESAMPLE_CYC cycles.
- R7: Any change on wake clears both status registers, with the set-wins rule still applied.
- R8: Bits A0 (thermal shutdown), A1 (input undervoltage), B0 and B1 (bulk converter undervoltage) cause a one-cycle sd_ordered pulse. B2 (common-voltage fault) causes a one-cycle sd_immediate pulse, which takes precedence over an ordered pulse in the same cycle and escalates an ordered shutdown that is already in progress. The two pulses are never high together.
- R9: reenable_blocked is 1 from the cycle of a shutdown pulse until one cycle after the last relevant shutdown-class bit clears.
- R10: Rail undervoltage bits B3..B6 set their flag and pull irq_n low, but they request no shutdown.
- R11: pgood_n is registered. It is 0 one cycle after all four rail_en and rail_ok bits are 1 while the state machine is in SD_RUN, and 1 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_a | input | 8 | Group A fault/event sources |
| src_b | input | 8 | Group B fault/event sources |
| wake | input | 1 | Wake level; any change clears status |
| rd_strobe | input | 1 | Register read strobe |
| rd_addr | input | 2 | Read address |
| rd_data | output | 8 | Registered read data |
| wr_strobe | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address |
| wr_data | input | 8 | Write data |
| rail_en | input | 4 | Secondary rail enables |
| rail_ok | input | 4 | Secondary rail in-regulation flags |
| irq_n | output | 1 | Active-low interrupt |
| pgood_n | output | 1 | Active-low power-good (1 = not good) |
| sd_ordered | output | 1 | Ordered-shutdown request pulse |
| sd_immediate | output | 1 | Immediate-shutdown request pulse |
| reenable_blocked | output | 1 | Rails may not be re-enabled |

## Verification
The bench targets an event that coincides with a clearing read. A design that let the clear win would lose that event, so the following read would return 0. It holds a rail undervoltage across a read to show that the bit sets again within one resample period and that no shutdown pulse appears; a design that sampled levels continuously, or that classified rail faults as shutdowns, would differ in irq_n timing or in the pulse counters. It also drives a level between resample ticks, masks an event to show that only the pin is gated, escalates a thermal shutdown with a common-voltage fault, and toggles wake. A reference model is compared against every output on every cycle.

// File: rtl/irq_fault_pkg.sv
package irq_fault_pkg;
    localparam int REG_W  = 8;
    localparam int ADDR_W = 2;
    localparam int RAIL_N = 4;

    localparam logic [ADDR_W-1:0] ADR_STAT_A = 2'd0;
    localparam logic [ADDR_W-1:0] ADR_STAT_B = 2'd1;
    localparam logic [ADDR_W-1:0] ADR_EN_A   = 2'd2;
    localparam logic [ADDR_W-1:0] ADR_EN_B   = 2'd3;

    // which source bits are levels (sampled on the tick); others are events
    localparam logic [REG_W-1:0] LVL_MASK_A = 8'h07;
    localparam logic [REG_W-1:0] LVL_MASK_B = 8'h7F;
    // shutdown classes
    localparam logic [REG_W-1:0] ORD_MASK_A = 8'h03;
    localparam logic [REG_W-1:0] ORD_MASK_B = 8'h03;
    localparam logic [REG_W-1:0] IMM_MASK_B = 8'h04;
    // enable reset values
    localparam logic [REG_W-1:0] EN_A_RST   = 8'hDF;
    localparam logic [REG_W-1:0] EN_B_RST   = 8'hFF;

    typedef enum logic [2:0] {
        SD_RUN      = 3'd0,
        SD_ORDER    = 3'd1,
        SD_IMMED    = 3'd2,
        SD_HOLD_ORD = 3'd3,
        SD_HOLD_IMM = 3'd4
    } sd_state_e;
endpackage

// File: rtl/irq_sample_timer.sv
module irq_sample_timer #(
    parameter int CYC = 3000
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int CNT_W = (CYC > 2) ? $clog2(CYC) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(CYC - 1);

    logic [CNT_W-1:0] cnt;

    assign tick = (cnt == LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (tick) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/irq_status_reg.sv
module irq_status_reg #(
    parameter int              W          = 8,
    parameter logic [W-1:0]    LEVEL_MASK = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] src,
    input  logic         tick,
    input  logic         clr,
    output logic [W-1:0] status
);
    logic [W-1:0] set_vec;

    // events latch at once; levels only on the resample tick
    assign set_vec = (src & ~LEVEL_MASK) | (src & LEVEL_MASK & {W{tick}});

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            status <= '0;
        end else begin
            status <= (status & ~{W{clr}}) | set_vec;
        end
    end
endmodule

// File: rtl/irq_sd_fsm.sv
module irq_sd_fsm
    import irq_fault_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic ord_hit,
    input  logic imm_hit,
    input  logic rails_good,
    output logic sd_ordered,
    output logic sd_immediate,
    output logic blocked,
    output logic pgood_n
);
    sd_state_e state, state_nx;

    always_comb begin
        state_nx = state;
        unique case (state)
            SD_RUN: begin
                if (imm_hit)      state_nx = SD_IMMED;
                else if (ord_hit) state_nx = SD_ORDER;
            end
            SD_ORDER: begin
                if (imm_hit) state_nx = SD_IMMED;
                else         state_nx = SD_HOLD_ORD;
            end
            SD_IMMED: state_nx = SD_HOLD_IMM;
            SD_HOLD_ORD: begin
                if (imm_hit)      state_nx = SD_IMMED;
                else if (!ord_hit) state_nx = SD_RUN;
            end
            SD_HOLD_IMM: begin
                if (!(imm_hit || ord_hit)) state_nx = SD_RUN;
            end
            default: state_nx = SD_RUN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= SD_RUN;
        else        state <= state_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pgood_n <= 1'b1;
        else        pgood_n <= !(rails_good && (state == SD_RUN));
    end

    assign sd_ordered   = (state == SD_ORDER);
    assign sd_immediate = (state == SD_IMMED);
    assign blocked      = (state != SD_RUN);
endmodule

// File: rtl/irq_fault_unit.sv
module irq_fault_unit
    import irq_fault_pkg::*;
#(
    parameter int RESAMPLE_CYC = 3000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [REG_W-1:0]  src_a,
    input  logic [REG_W-1:0]  src_b,
    input  logic              wake,
    input  logic              rd_strobe,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [REG_W-1:0]  rd_data,
    input  logic              wr_strobe,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [REG_W-1:0]  wr_data,
    input  logic [RAIL_N-1:0] rail_en,
    input  logic [RAIL_N-1:0] rail_ok,
    output logic              irq_n,
    output logic              pgood_n,
    output logic              sd_ordered,
    output logic              sd_immediate,
    output logic              reenable_blocked
);
    localparam int GRP_N = 2;
    localparam logic [GRP_N-1:0][REG_W-1:0] LVL_MASKS = {LVL_MASK_B, LVL_MASK_A};

    logic                         tick;
    logic                         wake_q;
    logic                         wake_tog;
    logic [GRP_N-1:0][REG_W-1:0]  src_g;
    logic [GRP_N-1:0][REG_W-1:0]  stat_g;
    logic [GRP_N-1:0]             clr_g;
    logic [REG_W-1:0]             en_a;
    logic [REG_W-1:0]             en_b;

    assign src_g    = {src_b, src_a};
    assign wake_tog = wake ^ wake_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) wake_q <= 1'b0;
        else        wake_q <= wake;
    end

    irq_sample_timer #(.CYC(RESAMPLE_CYC)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick)
    );

    for (genvar g = 0; g < GRP_N; g++) begin : g_bank
        assign clr_g[g] = wake_tog || (rd_strobe && (rd_addr == ADDR_W'(g)));
        irq_status_reg #(.W(REG_W), .LEVEL_MASK(LVL_MASKS[g])) u_stat (
            .clk    (clk),
            .rst_n  (rst_n),
            .src    (src_g[g]),
            .tick   (tick),
            .clr    (clr_g[g]),
            .status (stat_g[g])
        );
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_a <= EN_A_RST;
            en_b <= EN_B_RST;
        end else if (wr_strobe) begin
            if (wr_addr == ADR_EN_A) en_a <= wr_data;
            if (wr_addr == ADR_EN_B) en_b <= wr_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_data <= '0;
        end else if (rd_strobe) begin
            case (rd_addr)
                ADR_STAT_A: rd_data <= stat_g[0];
                ADR_STAT_B: rd_data <= stat_g[1];
                ADR_EN_A:   rd_data <= en_a;
                ADR_EN_B:   rd_data <= en_b;
                default:    rd_data <= '0;
            endcase
        end
    end

    assign irq_n = !((|(stat_g[0] & en_a)) || (|(stat_g[1] & en_b)));

    irq_sd_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .ord_hit      ((|(stat_g[0] & ORD_MASK_A)) || (|(stat_g[1] & ORD_MASK_B))),
        .imm_hit      (|(stat_g[1] & IMM_MASK_B)),
        .rails_good   (&(rail_en & rail_ok)),
        .sd_ordered   (sd_ordered),
        .sd_immediate (sd_immediate),
        .blocked      (reenable_blocked),
        .pgood_n      (pgood_n)
    );
endmodule

// File: rtl/irq_fault_unit_chk.sv
module irq_fault_unit_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [7:0] src_a,
    input logic       rd_strobe,
    input logic [1:0] rd_addr,
    input logic [7:0] sta,
    input logic [7:0] stb,
    input logic       irq_n,
    input logic       pgood_n,
    input logic [3:0] rail_en,
    input logic [3:0] rail_ok,
    input logic       sd_ordered,
    input logic       sd_immediate,
    input logic       reenable_blocked
);
    AST_EVT_SETS_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        src_a[7] |=> sta[7]); // R2

    AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_strobe && rd_addr == 2'd0 && src_a == 8'h00) |=> (sta == 8'h00)); // R5

    AST_IRQ_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (sta == 8'h00 && stb == 8'h00) |-> irq_n); // R4

    AST_SD_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(sd_ordered && sd_immediate)); // R8

    AST_SD_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        sd_ordered |=> !sd_ordered); // R8

    AST_SD_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        (sd_ordered || sd_immediate) |-> reenable_blocked); // R9

    AST_PGOOD_RAILS: assert property (@(posedge clk) disable iff (!rst_n)
        !pgood_n |-> $past(&(rail_en & rail_ok))); // R11
endmodule

bind irq_fault_unit irq_fault_unit_chk i_chk (
    .clk              (clk),
    .rst_n            (rst_n),
    .src_a            (src_a),
    .rd_strobe        (rd_strobe),
    .rd_addr          (rd_addr),
    .sta              (stat_g[0]),
    .stb              (stat_g[1]),
    .irq_n            (irq_n),
    .pgood_n          (pgood_n),
    .rail_en          (rail_en),
    .rail_ok          (rail_ok),
    .sd_ordered       (sd_ordered),
    .sd_immediate     (sd_immediate),
    .reenable_blocked (reenable_blocked)
);

// File: tb/test_irq_fault_unit.sv
`timescale 1ns/1ps
module test_irq_fault_unit;
    localparam int RS = 20;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] src_a = 8'h00, src_b = 8'h00;
    logic       wake = 1'b0;
    logic       rd_strobe = 1'b0;
    logic [1:0] rd_addr = 2'd0;
    logic [7:0] rd_data;
    logic       wr_strobe = 1'b0;
    logic [1:0] wr_addr = 2'd0;
    logic [7:0] wr_data = 8'h00;
    logic [3:0] rail_en = 4'h0, rail_ok = 4'h0;
    logic       irq_n, pgood_n, sd_ordered, sd_immediate, reenable_blocked;

    int checks = 0;
    int errors = 0;
    int n_ord = 0;
    int n_imm = 0;

    always #5 clk = ~clk;

    irq_fault_unit #(.RESAMPLE_CYC(RS)) i_irq_fault_unit (
        .clk(clk), .rst_n(rst_n), .src_a(src_a), .src_b(src_b), .wake(wake),
        .rd_strobe(rd_strobe), .rd_addr(rd_addr), .rd_data(rd_data),
        .wr_strobe(wr_strobe), .wr_addr(wr_addr), .wr_data(wr_data),
        .rail_en(rail_en), .rail_ok(rail_ok), .irq_n(irq_n), .pgood_n(pgood_n),
        .sd_ordered(sd_ordered), .sd_immediate(sd_immediate),
        .reenable_blocked(reenable_blocked)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // ---------------- reference model ----------------
    int         m_cnt;
    logic       m_wq;
    logic [7:0] m_sa, m_sb, m_ea, m_eb, m_rd;
    int         m_st;      // 0 run,1 order,2 immed,3 hold-ord,4 hold-imm
    logic       m_pg_n;
    logic       t_tick, t_wtog, t_ord, t_imm;
    logic [7:0] t_seta, t_setb, t_clra, t_clrb;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_cnt = 0; m_wq = 1'b0; m_sa = 8'h00; m_sb = 8'h00;
            m_ea = 8'hDF; m_eb = 8'hFF; m_rd = 8'h00; m_st = 0; m_pg_n = 1'b1;
        end else begin
            t_tick = (m_cnt == RS - 1);
            m_cnt  = t_tick ? 0 : m_cnt + 1;
            t_wtog = (wake != m_wq);
            m_wq   = wake;
            t_seta = (src_a & 8'hF8) | (t_tick ? (src_a & 8'h07) : 8'h00);
            t_setb = (src_b & 8'h80) | (t_tick ? (src_b & 8'h7F) : 8'h00);
            t_clra = (t_wtog || (rd_strobe && rd_addr == 2'd0)) ? 8'hFF : 8'h00;
            t_clrb = (t_wtog || (rd_strobe && rd_addr == 2'd1)) ? 8'hFF : 8'h00;
            if (rd_strobe) begin
                case (rd_addr)
                    2'd0: m_rd = m_sa;
                    2'd1: m_rd = m_sb;
                    2'd2: m_rd = m_ea;
                    default: m_rd = m_eb;
                endcase
            end
            t_ord  = (m_sa[0] | m_sa[1] | m_sb[0] | m_sb[1]);
            t_imm  = m_sb[2];
            m_pg_n = !((rail_en == 4'hF) && (rail_ok == 4'hF) && (m_st == 0));
            case (m_st)
                0: m_st = t_imm ? 2 : (t_ord ? 1 : 0);
                1: m_st = t_imm ? 2 : 3;
                2: m_st = 4;
                3: m_st = t_imm ? 2 : (t_ord ? 3 : 0);
                default: m_st = (t_imm || t_ord) ? 4 : 0;
            endcase
            if (wr_strobe && wr_addr == 2'd2) m_ea = wr_data;
            if (wr_strobe && wr_addr == 2'd3) m_eb = wr_data;
            m_sa = (m_sa & ~t_clra) | t_seta;
            m_sb = (m_sb & ~t_clrb) | t_setb;
        end
    end

    always @(negedge clk) begin
        if (rst_n) begin
            chk("R4 irq_n model", irq_n, !(|(m_sa & m_ea) || |(m_sb & m_eb)));
            chk("R11 pgood_n model", pgood_n, m_pg_n);
            chk("R8 sd_ordered model", sd_ordered, m_st == 1);
            chk("R8 sd_immediate model", sd_immediate, m_st == 2);
            chk("R9 blocked model", reenable_blocked, m_st != 0);
            chk("R2 rd_data model", rd_data, m_rd);
            if (sd_ordered) n_ord++;
            if (sd_immediate) n_imm++;
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk); rd_strobe = 1'b1; rd_addr = a;
        @(negedge clk); rd_strobe = 1'b0; d = rd_data;
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk); wr_strobe = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk); wr_strobe = 1'b0;
    endtask

    initial begin
        #2_000_000;
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] d;
        int o0, i0;
        cyc(3);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 irq_n", irq_n, 1'b1);
        chk("R1 pgood_n", pgood_n, 1'b1);
        chk("R1 blocked", reenable_blocked, 1'b0);
        rd(2'd2, d); chk("R1 enable A reset", d, 8'hDF);
        rd(2'd3, d); chk("R1 enable B reset", d, 8'hFF);
        rd(2'd0, d); chk("R1 status A reset", d, 8'h00);

        // R2 event sets bit, irq follows
        @(negedge clk); src_a = 8'h80; @(negedge clk); src_a = 8'h00;
        chk("R2 irq_n low after event", irq_n, 1'b0);
        rd(2'd0, d); chk("R2 status A event", d, 8'h80);
        chk("R5 irq released after read", irq_n, 1'b1);

        // R4 temperature-change bit masked by reset enable
        @(negedge clk); src_a = 8'h20; @(negedge clk); src_a = 8'h00;
        chk("R4 masked bit keeps irq_n high", irq_n, 1'b1);
        rd(2'd0, d); chk("R4 masked bit still set", d, 8'h20);

        // R4 write to status ignored; enable write masks pin only
        wr(2'd0, 8'hFF);
        rd(2'd0, d); chk("R4 status write ignored", d, 8'h00);
        wr(2'd2, 8'h00);
        @(negedge clk); src_a = 8'h40; @(negedge clk); src_a = 8'h00;
        chk("R4 irq_n with mask 0", irq_n, 1'b1);
        rd(2'd0, d); chk("R4 status set despite mask", d, 8'h40);
        wr(2'd2, 8'hDF);

        // R5 set wins over clearing read
        @(negedge clk); rd_strobe = 1'b1; rd_addr = 2'd1; src_b = 8'h80;
        @(negedge clk); rd_strobe = 1'b0; src_b = 8'h00;
        chk("R5 read returns pre-set value", rd_data, 8'h00);
        rd(2'd1, d); chk("R5 coincident set retained", d, 8'h80);

        // R3 level between ticks is ignored
        while (m_cnt != 0) @(negedge clk);
        src_a = 8'h04; @(negedge clk); src_a = 8'h00;
        rd(2'd0, d); chk("R3 level off tick ignored", d, 8'h00);

        // R3/R6/R10 persistent rail undervoltage
        o0 = n_ord; i0 = n_imm;
        src_b = 8'h08;
        cyc(RS + 2);
        chk("R3 level captured within period", irq_n, 1'b0);
        rd(2'd1, d); chk("R3 rail UV bit", d, 8'h08);
        cyc(RS + 1);
        chk("R6 persistent fault re-sets", irq_n, 1'b0);
        rd(2'd1, d); chk("R6 rail UV bit again", d, 8'h08);
        chk("R10 no shutdown from rail UV", n_ord + n_imm, o0 + i0);
        src_b = 8'h00;
        cyc(2);
        rd(2'd1, d);
        rd(2'd1, d); chk("R10 rail UV cleared", d, 8'h00);

        // R11 power-good
        rail_en = 4'hF; rail_ok = 4'hF;
        cyc(2); chk("R11 pgood asserted", pgood_n, 1'b0);
        rail_ok = 4'hB;
        cyc(2); chk("R11 pgood released on rail loss", pgood_n, 1'b1);
        rail_ok = 4'hF;
        cyc(2);

        // R8/R9 ordered then escalated shutdown
        o0 = n_ord; i0 = n_imm;
        src_a = 8'h01;
        cyc(RS + 3);
        chk("R8 ordered pulse count", n_ord - o0, 1);
        chk("R9 blocked after ordered", reenable_blocked, 1'b1);
        chk("R11 pgood not good while blocked", pgood_n, 1'b1);
        src_b = 8'h04;
        cyc(RS + 3);
        chk("R8 immediate escalation", n_imm - i0, 1);
        src_a = 8'h00; src_b = 8'h00;
        cyc(1);
        rd(2'd0, d); rd(2'd1, d);
        cyc(2);
        chk("R9 unblocked after clear", reenable_blocked, 1'b0);

        // R7 wake toggle clears status
        @(negedge clk); src_a = 8'h08; src_b = 8'h80;
        @(negedge clk); src_a = 8'h00; src_b = 8'h00;
        wake = 1'b1;
        cyc(2);
        chk("R7 irq released by wake", irq_n, 1'b1);
        rd(2'd0, d); chk("R7 status A cleared", d, 8'h00);
        rd(2'd1, d); chk("R7 status B cleared", d, 8'h00);

        cyc(5);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule